// File: doc/BRIEF.md
# High-Speed Idle Suspend/Reset Discriminator

This block watches the bus on the device side while the link runs at high speed, and decides what a silent bus means. At high speed an idle bus and a single-ended zero look the same, so a quiet bus cannot be classified at once. After a run of timebase ticks with no bus activity, the block drops back to full-speed signalling. It removes the high-speed termination and connects the D+ pull-up. After a short settle window it samples the line. A J state means the host has suspended the link. A continuing single-ended zero means a bus reset, and the block hands control to the chirp speed-detection handshake.

While suspended, the block watches for two things. A single-ended zero that lasts long enough is a reset: the block wakes up and starts the full chirp handshake. A K state held long enough, followed by its release, is a resume. The block leaves suspend and returns to the speed it had before it was suspended. A device suspended from high speed goes back to high-speed termination directly, with no chirp. A device suspended from full speed stays at full speed. The handshake itself, analog wake-up and clock start-up are outside the block. The handshake reports its outcome back on `hand_done` and `hand_hs`.

All time windows are counted in ticks of `tick`, which is a one-cycle strobe from a shared timebase. By default the windows assume one tick per microsecond.

Top module: `hs_idle_monitor`

## Requirements
- R1: After synchronous reset, `pullup_en` is 1, `hs_term_en` is 0, `suspended` is 0, and both `reset_det` and `resume_done` are 0.
- R2: In high-speed operation, when `bus_active` is low for IDLE_TICKS consecutive ticks, `hs_term_en` falls to 0 and `pullup_en` rises to 1 on that clock edge. Before that edge the outputs are unchanged.
- R3: A high `bus_active` sample before the idle threshold is reached restarts the idle count, so idle gaps shorter than IDLE_TICKS never cause a reversion.
- R4: Line encoding on `line_state` is 00 = SE0, 01 = J, 10 = K, 11 = SE1. If the line is J at the end of the SETTLE_TICKS window after reversion, `suspended` rises and the operating speed is latched.
- R5: If the line is SE0 at the end of the settle window, `reset_det` pulses high for exactly one cycle, and the pads stay at full speed until `hand_done`. At `hand_done`, `hand_hs` = 1 selects high-speed termination and 0 selects full speed.
- R6: If the line is K or SE1 at the end of the settle window, the block returns to the speed it had before reversion, and no `reset_det` pulse occurs.
- R7: While suspended, SE0 held steady for more than RST_TICKS ticks produces one `reset_det` pulse and clears `suspended`.
- R8: While suspended, a K held for at least RESUME_TICKS ticks and then released produces one `resume_done` pulse on the edge that sees the release. `suspended` clears, no `reset_det` occurs, and a link suspended from high speed gets `hs_term_en` = 1 in that same cycle.
- R9: While suspended, K bursts shorter than RESUME_TICKS ticks are ignored: `suspended` stays 1 and `resume_done` stays 0.
- R10: A link suspended from full-speed operation resumes with `pullup_en` = 1 and `hs_term_en` = 0.
- R11: All timers advance only on cycles where `tick` is 1. With `tick` held low, no idle reversion occurs however long the bus is quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase strobe; one tick advances every window counter |
| line_state | input | 2 | Decoded line: 00 SE0, 01 J, 10 K, 11 SE1 |
| bus_active | input | 1 | High-speed packet activity seen on the bus |
| hand_done | input | 1 | Chirp handshake finished |
| hand_hs | input | 1 | Handshake outcome: 1 high speed, 0 full speed |
| pullup_en | output | 1 | Connect the D+ pull-up |
| hs_term_en | output | 1 | Enable high-speed termination |
| suspended | output | 1 | Link is in suspend |
| reset_det | output | 1 | One-cycle pulse: bus reset recognised, start the handshake |
| resume_done | output | 1 | One-cycle pulse: resume signalling finished |

## Verification
The embedded properties check on every cycle that the reset pulse lasts one cycle and is always preceded by a sampled SE0. They check that a resume pulse only follows a released K seen from suspend, and that suspend is only entered from a sampled J. They also check that termination is only dropped after an idle sample, and that every counter holds while no tick arrives. The bench scenarios are what show the exact window lengths. Those are the reversion edge, the settle sampling point, the SE0 and K durations in suspend, and which speed is restored after each path through the block. The bench also drives randomised idle gaps and short K bursts to show that sub-threshold activity is ignored.

// File: rtl/hsm_pkg.sv
// Package: shared encodings for the idle/suspend monitor.
// Assumes the line decoder presents SE0/J/K/SE1 on two bits as below.
package hsm_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    typedef enum logic [1:0] {
        ST_RUN     = 2'b00,   // operating, counting idle time
        ST_PROBE   = 2'b01,   // reverted to full speed, settling
        ST_SLEEP   = 2'b10,   // suspended
        ST_HANDOFF = 2'b11    // waiting for the chirp handshake
    } mon_state_t;

endpackage

// File: rtl/hsm_timer.sv
// Module: tick-driven window counter.
// Counts enabled ticks, saturates at MAX_COUNT, clears synchronously.
// Assumes clr has priority over en.
module hsm_timer #(
    parameter int MAX_COUNT = 3000,
    localparam int CW = $clog2(MAX_COUNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    output logic [CW-1:0] cnt
);

    // Saturating count of enabled ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (en && (cnt != CW'(MAX_COUNT))) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R11
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(cnt));

    // R11
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt != '0) |=> (cnt != '0));

endmodule

// File: rtl/hsm_ctrl.sv
// Module: state machine for the idle/suspend/reset/resume decisions.
// Uses an idle/settle counter (A) and a line-stability counter (B),
// both external; it only produces their clear/enable strobes.
// Assumes tick is a single-cycle strobe and line_state is already synchronised.
module hsm_ctrl
    import hsm_pkg::*;
#(
    parameter int IDLE_TICKS   = 3000,
    parameter int SETTLE_TICKS = 100,
    parameter int RST_TICKS    = 3,
    parameter int RESUME_TICKS = 20000,
    localparam int AW = $clog2(((IDLE_TICKS > SETTLE_TICKS) ? IDLE_TICKS : SETTLE_TICKS) + 1),
    localparam int BW = $clog2(((RST_TICKS > RESUME_TICKS) ? RST_TICKS : RESUME_TICKS) + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [1:0]    line_state,
    input  logic          bus_active,
    input  logic          hand_done,
    input  logic          hand_hs,
    input  logic [AW-1:0] cnt_a,
    input  logic [BW-1:0] cnt_b,
    output logic          clr_a,
    output logic          en_a,
    output logic          clr_b,
    output logic          en_b,
    output logic          pullup_en,
    output logic          hs_term_en,
    output logic          suspended,
    output logic          reset_det,
    output logic          resume_done
);

    mon_state_t st_q;
    logic       hs_q;        // current operating speed
    logic       spd_q;       // speed latched at reversion
    logic [1:0] prev_q;      // line sample from the previous cycle
    logic       rst_q;
    logic       res_q;

    logic idle_cnt_on, idle_fire, probe_fire, line_steady, wake_rst, wake_res;

    // Previous line sample for stability tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= LS_J;
        else        prev_q <= line_state;
    end

    // Window strobes and decision conditions.
    always_comb begin
        idle_cnt_on = ((st_q == ST_RUN) && !bus_active) || (st_q == ST_PROBE);
        idle_fire   = (st_q == ST_RUN) && !bus_active && tick
                      && (cnt_a == AW'(IDLE_TICKS - 1));
        probe_fire  = (st_q == ST_PROBE) && tick && (cnt_a == AW'(SETTLE_TICKS - 1));
        clr_a       = !idle_cnt_on || idle_fire || probe_fire;
        en_a        = tick;

        line_steady = (line_state == prev_q);
        clr_b       = (st_q != ST_SLEEP) || !line_steady
                      || !((line_state == LS_SE0) || (line_state == LS_K));
        en_b        = tick;

        wake_res    = (st_q == ST_SLEEP) && (prev_q == LS_K) && (line_state != LS_K)
                      && (cnt_b >= BW'(RESUME_TICKS));
        wake_rst    = (st_q == ST_SLEEP) && (prev_q == LS_SE0) && line_steady
                      && (cnt_b >= BW'(RST_TICKS));
    end

    // Main state, speed bookkeeping and output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            hs_q  <= 1'b0;
            spd_q <= 1'b0;
            rst_q <= 1'b0;
            res_q <= 1'b0;
        end else begin
            rst_q <= 1'b0;
            res_q <= 1'b0;
            unique case (st_q)
                ST_RUN: begin
                    if (idle_fire) begin
                        spd_q <= hs_q;
                        hs_q  <= 1'b0;
                        st_q  <= ST_PROBE;
                    end
                end
                ST_PROBE: begin
                    if (probe_fire) begin
                        if (line_state == LS_J) begin
                            st_q <= ST_SLEEP;
                        end else if (line_state == LS_SE0) begin
                            rst_q <= 1'b1;
                            st_q  <= ST_HANDOFF;
                        end else begin
                            hs_q <= spd_q;
                            st_q <= ST_RUN;
                        end
                    end
                end
                ST_SLEEP: begin
                    if (wake_res) begin
                        hs_q  <= spd_q;
                        res_q <= 1'b1;
                        st_q  <= ST_RUN;
                    end else if (wake_rst) begin
                        rst_q <= 1'b1;
                        st_q  <= ST_HANDOFF;
                    end
                end
                ST_HANDOFF: begin
                    if (hand_done) begin
                        hs_q <= hand_hs;
                        st_q <= ST_RUN;
                    end
                end
                default: st_q <= ST_RUN;
            endcase
        end
    end

    // Pad controls and flags derived from state.
    always_comb begin
        hs_term_en  = (st_q == ST_RUN) && hs_q;
        pullup_en   = !hs_term_en;
        suspended   = (st_q == ST_SLEEP);
        reset_det   = rst_q;
        resume_done = res_q;
    end

    // R5
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_det |=> !reset_det);

    // R7
    rst_after_se0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_det |-> ($past(line_state) == LS_SE0));

    // R8
    resume_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_done |-> ($past(st_q) == ST_SLEEP) && ($past(prev_q) == LS_K));

    // R4
    sleep_from_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> ($past(line_state) == LS_J));

    // R2
    term_drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_term_en) |-> !$past(bus_active));

endmodule

// File: rtl/hs_idle_monitor.sv
// Module: top of the device-side high-speed idle suspend/reset discriminator.
// Wires two window counters to the decision state machine.
// Assumes tick is a one-cycle timebase strobe (default 1 us).
module hs_idle_monitor #(
    parameter int IDLE_TICKS   = 3000,
    parameter int SETTLE_TICKS = 100,
    parameter int RST_TICKS    = 3,
    parameter int RESUME_TICKS = 20000,
    localparam int A_MAX = (IDLE_TICKS > SETTLE_TICKS) ? IDLE_TICKS : SETTLE_TICKS,
    localparam int B_MAX = (RST_TICKS > RESUME_TICKS) ? RST_TICKS : RESUME_TICKS,
    localparam int AW    = $clog2(A_MAX + 1),
    localparam int BW    = $clog2(B_MAX + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] line_state,
    input  logic       bus_active,
    input  logic       hand_done,
    input  logic       hand_hs,
    output logic       pullup_en,
    output logic       hs_term_en,
    output logic       suspended,
    output logic       reset_det,
    output logic       resume_done
);

    logic [AW-1:0] cnt_a;
    logic [BW-1:0] cnt_b;
    logic clr_a, en_a, clr_b, en_b;

    hsm_timer #(.MAX_COUNT(A_MAX)) u_idle_timer (
        .clk(clk), .rst_n(rst_n), .clr(clr_a), .en(en_a), .cnt(cnt_a)
    );

    hsm_timer #(.MAX_COUNT(B_MAX)) u_line_timer (
        .clk(clk), .rst_n(rst_n), .clr(clr_b), .en(en_b), .cnt(cnt_b)
    );

    hsm_ctrl #(
        .IDLE_TICKS(IDLE_TICKS), .SETTLE_TICKS(SETTLE_TICKS),
        .RST_TICKS(RST_TICKS),   .RESUME_TICKS(RESUME_TICKS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_state(line_state),
        .bus_active(bus_active), .hand_done(hand_done), .hand_hs(hand_hs),
        .cnt_a(cnt_a), .cnt_b(cnt_b),
        .clr_a(clr_a), .en_a(en_a), .clr_b(clr_b), .en_b(en_b),
        .pullup_en(pullup_en), .hs_term_en(hs_term_en), .suspended(suspended),
        .reset_det(reset_det), .resume_done(resume_done)
    );

endmodule

// File: tb/hs_idle_monitor_tb_top.sv
// Bench: directed and seeded random scenarios for hs_idle_monitor.
module hs_idle_monitor_tb_top;

    localparam int IDLE   = 20;
    localparam int SETTLE = 4;
    localparam int RSTT   = 3;
    localparam int RES    = 30;

    localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10, SE1 = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic [1:0] line_state = J;
    logic bus_active = 1'b1;
    logic hand_done = 1'b0;
    logic hand_hs = 1'b0;
    logic pullup_en, hs_term_en, suspended, reset_det, resume_done;

    int checks = 0;
    int fails = 0;
    int n_rst = 0;
    int n_res = 0;

    always #10 clk = ~clk;   // 50 MHz

    hs_idle_monitor #(
        .IDLE_TICKS(IDLE), .SETTLE_TICKS(SETTLE), .RST_TICKS(RSTT), .RESUME_TICKS(RES)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_state(line_state),
        .bus_active(bus_active), .hand_done(hand_done), .hand_hs(hand_hs),
        .pullup_en(pullup_en), .hs_term_en(hs_term_en), .suspended(suspended),
        .reset_det(reset_det), .resume_done(resume_done)
    );

    // Pulse tallies sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && reset_det)   n_rst++;
        if (rst_n && resume_done) n_res++;
    end

    function automatic int pads(input logic pu, input logic term);
        return {30'd0, pu, term};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pads expected for a given speed: HS -> term only, FS -> pull-up only.
    function automatic int exp_pads(input bit hs);
        return hs ? pads(1'b0, 1'b1) : pads(1'b1, 1'b0);
    endfunction

    task automatic finish_hand(input bit hs);
        bus_active = 1'b1;
        hand_hs    = hs;
        hand_done  = 1'b1;
        run(1);
        hand_done  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int r0, q0;
        void'($urandom(32'd1234));
        run(3);
        // R1 reset state
        chk("R1 pads", pads(pullup_en, hs_term_en), exp_pads(1'b0));
        chk("R1 flags", {suspended, reset_det, resume_done}, 0);
        rst_n = 1'b1;
        run(1);

        // Full-speed SE0 idle -> reversion window -> reset handoff, grant HS (R5)
        bus_active = 1'b0; line_state = SE0;
        run(IDLE);
        r0 = n_rst;
        run(SETTLE);
        chk("R5 reset pulse", reset_det, 1);
        chk("R5 pads during handoff", pads(pullup_en, hs_term_en), exp_pads(1'b0));
        run(1);
        chk("R5 one-cycle pulse", reset_det, 0);
        finish_hand(1'b1);
        chk("R5 hs granted", pads(pullup_en, hs_term_en), exp_pads(1'b1));
        chk("R5 single pulse", n_rst - r0, 1);

        // R3 random idle gaps below the threshold
        for (int i = 0; i < 30; i++) begin
            bus_active = 1'b0;
            run($urandom_range(1, IDLE - 1));
            bus_active = 1'b1;
            run(1);
            if (hs_term_en != 1'b1) chk("R3 gap kept hs", hs_term_en, 1);
        end
        chk("R3 hs after gaps", hs_term_en, 1);

        // R11 no tick, no progress
        tick = 1'b0; bus_active = 1'b0;
        run(IDLE * 3);
        chk("R11 frozen without tick", hs_term_en, 1);
        bus_active = 1'b1; tick = 1'b1;
        run(1);

        // R2 exact reversion edge
        bus_active = 1'b0; line_state = SE0;
        run(IDLE - 1);
        chk("R2 before threshold", pads(pullup_en, hs_term_en), exp_pads(1'b1));
        run(1);
        chk("R2 reverted", pads(pullup_en, hs_term_en), exp_pads(1'b0));

        // R6 K at the sample point restores HS
        line_state = K; r0 = n_rst;
        run(SETTLE);
        bus_active = 1'b1;
        chk("R6 back to hs", pads(pullup_en, hs_term_en), exp_pads(1'b1));
        chk("R6 no reset", n_rst - r0, 0);
        run(1);

        // R6 SE1 also restores HS
        bus_active = 1'b0; line_state = SE0;
        run(IDLE);
        line_state = SE1;
        run(SETTLE);
        bus_active = 1'b1;
        chk("R6 se1 back to hs", hs_term_en, 1);
        run(1);

        // R4 suspend from HS
        bus_active = 1'b0; line_state = SE0;
        run(IDLE);
        line_state = J;
        run(SETTLE - 1);
        chk("R4 not yet suspended", suspended, 0);
        run(1);
        chk("R4 suspended", suspended, 1);
        chk("R4 pads fs", pads(pullup_en, hs_term_en), exp_pads(1'b0));

        // R9 short K bursts ignored
        q0 = n_res;
        for (int i = 0; i < 6; i++) begin
            line_state = K;
            run($urandom_range(1, RES - 2));
            line_state = J;
            run(3);
        end
        chk("R9 still suspended", suspended, 1);
        chk("R9 no resume", n_res - q0, 0);

        // R8 long K then release -> resume to HS
        r0 = n_rst;
        line_state = K;
        run(RES + 5);
        chk("R8 still suspended during K", suspended, 1);
        line_state = J;
        run(1);
        bus_active = 1'b1;
        chk("R8 resume pulse", resume_done, 1);
        chk("R8 hs restored", pads(pullup_en, hs_term_en), exp_pads(1'b1));
        chk("R8 left suspend", suspended, 0);
        run(1);
        chk("R8 one-cycle pulse", resume_done, 0);
        chk("R8 no chirp reset", n_rst - r0, 0);

        // R7 reset while suspended
        bus_active = 1'b0; line_state = SE0;
        run(IDLE);
        line_state = J;
        run(SETTLE);
        chk("R7 suspended first", suspended, 1);
        line_state = SE0;
        run(RSTT + 1);
        chk("R7 not yet reset", {suspended, reset_det}, 2);
        run(1);
        chk("R7 reset pulse", {suspended, reset_det}, 1);
        finish_hand(1'b0);
        chk("R5 fs granted", pads(pullup_en, hs_term_en), exp_pads(1'b0));

        // R10 suspend from full speed resumes at full speed
        bus_active = 1'b0; line_state = J;
        run(IDLE + SETTLE);
        chk("R10 suspended from fs", suspended, 1);
        line_state = K;
        run(RES + 5);
        line_state = J;
        run(1);
        chk("R10 resume pulse", resume_done, 1);
        chk("R10 fs pads", pads(pullup_en, hs_term_en), exp_pads(1'b0));
        bus_active = 1'b1;
        run(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule